// File: doc/BRIEF.md
# Camera Receiver Control and Status Register Bank

This block is the register file that sits beside a serial camera interface receiver. Software reaches it through a single-cycle read/write port. It sees global control, PHY control, stream configuration, frame resolution, and an interrupt mask and source pair. The block drives the configuration fields that the receiver datapath uses. It collects one-cycle event pulses from that datapath into sticky status bits, and it raises one interrupt line whenever an enabled status bit is set.

Stream configuration is double-buffered. Software writes the data type, the lane count, the resolution and the HS settle count into staging registers. These values reach the datapath only when software writes the update request bit. That bit clears itself one cycle later, when the staged values are committed. A soft reset bit starts a fixed-length hold sequence, built as a two-state machine:
- **RST_IDLE** goes to **RST_HOLD** on a write of 1 to the reset bit.
- **RST_HOLD** returns to **RST_IDLE** when its cycle counter reaches the end.

While the machine is in RST_HOLD, all status bits are held clear and the receiver enable is forced low.

The four start-of-transmission error bits share one mask bit. Status bits are cleared by writing 1 to them. An event pulse that arrives in the same cycle as a clear of its bit keeps that bit set.

Top module: `csirx_regbank`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, and all configuration outputs are 0.
- R2: The control register (offset 0x00) has these fields. Each field reads back as written, except bits 4 and 16, which read their live state. Bits 8, 20 and 31 drive their outputs from the cycle after the write.
  - bit 0: receiver enable
  - bit 4: soft reset
  - bit 8: external wrapper clock select
  - bit 16: update request
  - bit 20: 32-bit output alignment
  - bit 31: lane polarity swap
- R3: The PHY control register (offset 0x04) has two fields.
  - Bits [4:0] are the lane enables. They drive `lane_en` directly after the write.
  - Bits [31:27] are the HS settle count. This field is staged.
- R4: The configuration register (offset 0x08) holds the data type in [7:2] and the lane count minus one in [1:0]. The resolution register (offset 0x2C) holds the width in [31:16] and the height in [15:0]. Both registers read back their staged values. The active outputs `data_type`, `lane_cnt_m1`, `pix_width`, `pix_height` and `hs_settle` do not change until a commit.
- R5: Writing 1 to control bit 16 sets the update request. In the next cycle the staged fields are copied to the active outputs and the bit reads 0 again.
- R6: Event pulses set sticky bits in the source register (offset 0x14). The bit mapping is:
  - `evt_nonimg[3:0]` to bits [31:28]
  - `evt_fs` to bit 27
  - `evt_fe` to bit 26
  - `evt_sot[3:0]` to bits [15:12]
  - `evt_err[5:0]` to bits [5:0]
- R7: A write to the source register clears exactly the bits written as 1. All other set bits remain set.
- R8: An event pulse in the same cycle as a clear write of its bit leaves that bit set.
- R9: `irq` is the OR of the source bits ANDed with the mask (offset 0x10). Mask bit 12 gates all four source bits [15:12]. Unmasked set bits do not raise `irq`.
- R10: Writing 1 to control bit 4 starts a soft reset. Bit 4 then reads 1 for 8 cycles and returns to 0. During that time:
  - the source register is held at 0 and events are ignored;
  - `rx_enable` is 0;
  - the enable bit is cleared.
- R11: Only mask bits 31:26, 12 and 5:0 are implemented (value 0xFC00103F). All other mask bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| evt_nonimg | input | 4 | Non-image data event pulses |
| evt_fs | input | 1 | Frame start pulse |
| evt_fe | input | 1 | Frame end pulse |
| evt_sot | input | 4 | Start-of-transmission error pulses, one per lane |
| evt_err | input | 6 | Lost-FS, lost-FE, overflow, ECC, CRC and unknown error pulses |
| irq | output | 1 | Interrupt request |
| rx_enable | output | 1 | Receiver enable |
| ext_wclk | output | 1 | External wrapper clock select |
| align32 | output | 1 | 1 = 32-bit alignment, 0 = 24-bit alignment |
| lane_swap | output | 1 | Lane polarity swap |
| lane_en | output | 5 | Clock and data lane enables |
| hs_settle | output | 5 | Active HS settle count |
| data_type | output | 6 | Active data type |
| lane_cnt_m1 | output | 2 | Active lane count minus one |
| pix_width | output | 16 | Active frame width |
| pix_height | output | 16 | Active frame height |

## Verification
The bench tests the staging path in two steps. It writes configuration values that differ from the active ones, and only later commits them. This shows whether outputs follow the staging registers, or wait until the cycle after the update request. The status path is driven with a sparse pattern spread across every field. It is then cleared with a partial W1C pattern, and then cleared again while a pulse collides with the clear. These steps expose mis-mapped bits, clears that reach too many bits, and a clear that wins over an event. Mask patterns of all ones, only bit 12, and only the unimplemented bit 13 separate a correct shared SOT gate from a per-bit gate. A pulse inside the soft reset window, together with counting its exact length, checks both the hold-clear behaviour and the 8-cycle duration.

// File: rtl/csirx_pkg.sv
package csirx_pkg;
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_PHY   = 'h04;
    localparam int OFS_CFG   = 'h08;
    localparam int OFS_MASK  = 'h10;
    localparam int OFS_SRC   = 'h14;
    localparam int OFS_RES   = 'h2C;

    localparam int B_EN    = 0;
    localparam int B_SRST  = 4;
    localparam int B_WCLK  = 8;
    localparam int B_UPD   = 16;
    localparam int B_ALIGN = 20;
    localparam int B_SWAP  = 31;

    localparam int SOT_LO  = 12;
    localparam int SOT_N   = 4;

    localparam logic [31:0] SRC_IMPL = 32'hFC00_F03F;
    localparam logic [31:0] MSK_IMPL = 32'hFC00_103F;

    typedef struct packed {
        logic [4:0]  settle;
        logic [5:0]  dtype;
        logic [1:0]  lanes;
        logic [15:0] width;
        logic [15:0] height;
    } stream_cfg_t;

    typedef enum logic [0:0] {
        RST_IDLE = 1'b0,
        RST_HOLD = 1'b1
    } rst_state_e;
endpackage

// File: rtl/csirx_reset_seq.sv
module csirx_reset_seq #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    import csirx_pkg::*;

    localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

    rst_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RST_IDLE: begin
                cnt_d = '0;
                if (start) state_d = RST_HOLD;
            end
            RST_HOLD: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = RST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = RST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == RST_HOLD);
    end
endmodule

// File: rtl/csirx_irq_status.sv
module csirx_irq_status (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold_clear,
    input  logic        clr_we,
    input  logic [31:0] clr_bits,
    input  logic [31:0] evt_vec,
    input  logic [31:0] mask_q,
    output logic [31:0] src_q,
    output logic        irq
);
    import csirx_pkg::*;

    logic [31:0] mask_exp;

    for (genvar i = 0; i < 32; i++) begin : g_mask
        if (i >= SOT_LO && i < SOT_LO + SOT_N) begin : g_sot
            assign mask_exp[i] = mask_q[SOT_LO];
        end else begin : g_plain
            assign mask_exp[i] = mask_q[i];
        end
    end

    logic [31:0] clr_eff;
    assign clr_eff = clr_we ? clr_bits : 32'h0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          src_q <= '0;
        else if (hold_clear) src_q <= '0;
        else                 src_q <= ((src_q & ~clr_eff) | evt_vec) & SRC_IMPL;
    end

    assign irq = |(src_q & mask_exp);
endmodule

// File: rtl/csirx_shadow_cfg.sv
module csirx_shadow_cfg (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_req,
    input  csirx_pkg::stream_cfg_t stg,
    output logic                   upd_q,
    output csirx_pkg::stream_cfg_t act
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
            act   <= '0;
        end else begin
            upd_q <= upd_req;
            if (upd_q) act <= stg;
        end
    end
endmodule

// File: rtl/csirx_regbank.sv
module csirx_regbank #(
    parameter int ADDR_W      = 8,
    parameter int HOLD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        evt_nonimg,
    input  logic              evt_fs,
    input  logic              evt_fe,
    input  logic [3:0]        evt_sot,
    input  logic [5:0]        evt_err,
    output logic              irq,
    output logic              rx_enable,
    output logic              ext_wclk,
    output logic              align32,
    output logic              lane_swap,
    output logic [4:0]        lane_en,
    output logic [4:0]        hs_settle,
    output logic [5:0]        data_type,
    output logic [1:0]        lane_cnt_m1,
    output logic [15:0]       pix_width,
    output logic [15:0]       pix_height
);
    import csirx_pkg::*;

    logic wr;
    logic wr_ctrl, wr_phy, wr_cfg, wr_mask, wr_src, wr_res;
    assign wr      = bus_sel && bus_we;
    assign wr_ctrl = wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_phy  = wr && (bus_addr == ADDR_W'(OFS_PHY));
    assign wr_cfg  = wr && (bus_addr == ADDR_W'(OFS_CFG));
    assign wr_mask = wr && (bus_addr == ADDR_W'(OFS_MASK));
    assign wr_src  = wr && (bus_addr == ADDR_W'(OFS_SRC));
    assign wr_res  = wr && (bus_addr == ADDR_W'(OFS_RES));

    logic rst_busy;
    logic en_q, wclk_q, align_q, swap_q;
    logic [4:0]  lane_en_q;
    logic [4:0]  settle_stg;
    logic [7:0]  cfg_stg;
    logic [31:0] res_stg;
    logic [31:0] mask_q;
    logic [31:0] src_q;
    logic        upd_q;
    stream_cfg_t stg, act;

    csirx_reset_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_ctrl && bus_wdata[B_SRST]),
        .busy  (rst_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            wclk_q     <= 1'b0;
            align_q    <= 1'b0;
            swap_q     <= 1'b0;
            lane_en_q  <= '0;
            settle_stg <= '0;
            cfg_stg    <= '0;
            res_stg    <= '0;
            mask_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q    <= bus_wdata[B_EN];
                wclk_q  <= bus_wdata[B_WCLK];
                align_q <= bus_wdata[B_ALIGN];
                swap_q  <= bus_wdata[B_SWAP];
            end
            if (rst_busy) en_q <= 1'b0;
            if (wr_phy) begin
                lane_en_q  <= bus_wdata[4:0];
                settle_stg <= bus_wdata[31:27];
            end
            if (wr_cfg)  cfg_stg <= bus_wdata[7:0];
            if (wr_res)  res_stg <= bus_wdata;
            if (wr_mask) mask_q  <= bus_wdata & MSK_IMPL;
        end
    end

    assign stg = '{settle: settle_stg, dtype: cfg_stg[7:2], lanes: cfg_stg[1:0],
                   width: res_stg[31:16], height: res_stg[15:0]};

    csirx_shadow_cfg u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_req (wr_ctrl && bus_wdata[B_UPD]),
        .stg     (stg),
        .upd_q   (upd_q),
        .act     (act)
    );

    logic [31:0] evt_vec;
    always_comb begin
        evt_vec = '0;
        evt_vec[31:28] = evt_nonimg;
        evt_vec[27]    = evt_fs;
        evt_vec[26]    = evt_fe;
        evt_vec[SOT_LO +: SOT_N] = evt_sot;
        evt_vec[5:0]   = evt_err;
    end

    csirx_irq_status u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clear (rst_busy),
        .clr_we     (wr_src),
        .clr_bits   (bus_wdata),
        .evt_vec    (evt_vec),
        .mask_q     (mask_q),
        .src_q      (src_q),
        .irq        (irq)
    );

    logic [31:0] ctrl_rd;
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[B_EN]    = en_q;
        ctrl_rd[B_SRST]  = rst_busy;
        ctrl_rd[B_WCLK]  = wclk_q;
        ctrl_rd[B_UPD]   = upd_q;
        ctrl_rd[B_ALIGN] = align_q;
        ctrl_rd[B_SWAP]  = swap_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL))      bus_rdata = ctrl_rd;
        else if (bus_addr == ADDR_W'(OFS_PHY))  bus_rdata = {settle_stg, 22'h0, lane_en_q};
        else if (bus_addr == ADDR_W'(OFS_CFG))  bus_rdata = {24'h0, cfg_stg};
        else if (bus_addr == ADDR_W'(OFS_MASK)) bus_rdata = mask_q;
        else if (bus_addr == ADDR_W'(OFS_SRC))  bus_rdata = src_q;
        else if (bus_addr == ADDR_W'(OFS_RES))  bus_rdata = res_stg;
    end

    assign rx_enable   = en_q && !rst_busy;
    assign ext_wclk    = wclk_q;
    assign align32     = align_q;
    assign lane_swap   = swap_q;
    assign lane_en     = lane_en_q;
    assign hs_settle   = act.settle;
    assign data_type   = act.dtype;
    assign lane_cnt_m1 = act.lanes;
    assign pix_width   = act.width;
    assign pix_height  = act.height;
endmodule

// File: rtl/csirx_regbank_chk.sv
module csirx_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              rst_busy,
    input logic              upd_q,
    input logic [31:0]       src_q,
    input logic [31:0]       mask_q,
    input logic [31:0]       res_stg,
    input logic [15:0]       pix_width,
    input logic [5:0]        data_type,
    input logic              rx_enable,
    input logic              irq,
    input logic              evt_fs
);
    logic upd_write;
    assign upd_write = bus_sel && bus_we && (bus_addr == '0) && bus_wdata[16];

    assert_src_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |=> (src_q == 32'h0));

    assert_enable_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |-> !rx_enable);

    assert_upd_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q && !upd_write) |=> !upd_q);

    assert_commit_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |=> (pix_width == $past(res_stg[31:16])));

    assert_active_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_q |=> ($stable(pix_width) && $stable(data_type)));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_q == 32'h0) || (mask_q == 32'h0)) |-> !irq);

    assert_event_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_fs && !rst_busy) |=> src_q[27]);
endmodule

bind csirx_regbank csirx_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rst_busy  (rst_busy),
    .upd_q     (upd_q),
    .src_q     (src_q),
    .mask_q    (mask_q),
    .res_stg   (res_stg),
    .pix_width (pix_width),
    .data_type (data_type),
    .rx_enable (rx_enable),
    .irq       (irq),
    .evt_fs    (evt_fs)
);

// File: tb/csirx_regbank_tb.sv
module csirx_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  evt_nonimg = '0;
    logic        evt_fs = 1'b0, evt_fe = 1'b0;
    logic [3:0]  evt_sot = '0;
    logic [5:0]  evt_err = '0;
    logic        irq, rx_enable, ext_wclk, align32, lane_swap;
    logic [4:0]  lane_en, hs_settle;
    logic [5:0]  data_type;
    logic [1:0]  lane_cnt_m1;
    logic [15:0] pix_width, pix_height;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    csirx_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_nonimg(evt_nonimg), .evt_fs(evt_fs), .evt_fe(evt_fe),
        .evt_sot(evt_sot), .evt_err(evt_err), .irq(irq),
        .rx_enable(rx_enable), .ext_wclk(ext_wclk), .align32(align32),
        .lane_swap(lane_swap), .lane_en(lane_en), .hs_settle(hs_settle),
        .data_type(data_type), .lane_cnt_m1(lane_cnt_m1),
        .pix_width(pix_width), .pix_height(pix_height)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk("R1 ctrl", v, 0);
        rd(8'h14, v); chk("R1 src", v, 0);
        rd(8'h10, v); chk("R1 mask", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 outs", {rx_enable, lane_en, data_type, pix_width}, 0);
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        wr(8'h00, 32'h8010_0101);
        rd(8'h00, v); chk("R2 readback", v, 32'h8010_0101);
        chk("R2 outs", {rx_enable, ext_wclk, align32, lane_swap}, 4'hF);
    endtask

    task automatic t_phy;
        logic [31:0] v;
        wr(8'h04, 32'hF800_0007);
        chk("R3 lane_en live", lane_en, 5'h07);
        chk("R3 settle staged", hs_settle, 0);
        rd(8'h04, v); chk("R3 readback", v, 32'hF800_0007);
    endtask

    task automatic t_shadow;
        logic [31:0] v;
        wr(8'h08, 32'h0000_00AD);
        wr(8'h2C, 32'h0280_01E0);
        rd(8'h08, v); chk("R4 cfg readback", v, 32'hAD);
        rd(8'h2C, v); chk("R4 res readback", v, 32'h0280_01E0);
        chk("R4 active held", {data_type, lane_cnt_m1, pix_width, pix_height}, 0);
        wr(8'h00, 32'h8011_0101);
        rd(8'h00, v); chk("R5 upd reads 1", v[16], 1);
        chk("R5 not yet applied", data_type, 0);
        @(negedge clk);
        rd(8'h00, v); chk("R5 upd cleared", v[16], 0);
        chk("R5 dtype", data_type, 6'h2B);
        chk("R5 lanes", lane_cnt_m1, 2'd1);
        chk("R5 width", pix_width, 16'h0280);
        chk("R5 height", pix_height, 16'h01E0);
        chk("R5 settle", hs_settle, 5'd31);
    endtask

    task automatic t_events;
        logic [31:0] v;
        @(negedge clk);
        evt_nonimg = 4'b1010; evt_fs = 1; evt_sot = 4'b0100; evt_err = 6'b100001;
        @(negedge clk);
        evt_nonimg = 0; evt_fs = 0; evt_sot = 0; evt_err = 0;
        rd(8'h14, v); chk("R6 source map", v, 32'hA800_4021);
        chk("R9 no mask no irq", irq, 0);
        @(negedge clk);
        rd(8'h14, v); chk("R6 sticky", v, 32'hA800_4021);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R11 implemented mask", v, 32'hFC00_103F);
        chk("R9 irq all", irq, 1);
        wr(8'h10, 32'h0000_1000);
        chk("R9 bit12 gates sot14", irq, 1);
        wr(8'h10, 32'h0000_2000);
        rd(8'h10, v); chk("R11 bit13 absent", v, 0);
        chk("R9 irq off", irq, 0);
        wr(8'h10, 32'h0000_1000);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(8'h14, 32'h0800_4001);
        rd(8'h14, v); chk("R7 partial clear", v, 32'hA000_0020);
        chk("R9 sot gone irq low", irq, 0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 8'h14; bus_wdata = 32'hA000_0020;
        evt_fs = 1; evt_err = 6'b100000;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; evt_fs = 0; evt_err = 0;
        rd(8'h14, v); chk("R8 event beats clear", v, 32'h0800_0020);
    endtask

    task automatic t_softrst;
        logic [31:0] v;
        wr(8'h00, 32'h8010_0111);
        rd(8'h00, v); chk("R10 bit4 set", v[4], 1);
        chk("R10 enable low", rx_enable, 0);
        evt_fs = 1; evt_err = 6'h3F;
        @(negedge clk);
        evt_fs = 0; evt_err = 0;
        rd(8'h14, v); chk("R10 source held clear", v, 0);
        repeat (6) @(negedge clk);
        rd(8'h00, v); chk("R10 still busy at 8th cycle", v[4], 1);
        @(negedge clk);
        rd(8'h00, v); chk("R10 done after 8", v, 32'h8010_0100);
        chk("R10 enable stays off", rx_enable, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_phy();
        t_shadow();
        t_events();
        t_mask();
        t_w1c();
        t_race();
        t_softrst();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule